// File: doc/BRIEF.md
# Write-Back Invalidate Snooping Cache Controller

This block is the coherence controller of one processor's private cache in a small shared-bus multiprocessor. The cache is direct-mapped, write-back and write-allocate, with one data word per line. Each line is in one of three states. Invalid means the line holds nothing usable. Shared means the line holds a clean copy that may be read. Modified means the line holds the only valid copy, which may be written and is newer than memory. The controller serves processor loads and stores. For misses, upgrades and evictions it places transactions on an atomic shared bus. It also watches every transaction that other agents put on that bus.

When another agent misses on a block that this cache holds in Modified state, the controller intervenes. In the same cycle it drives the line's data out as a write-back and raises an abort signal, so that memory does not answer with its stale copy. A fresh read always installs its line as Shared, even when no other cache holds the block. A store that finds a line Shared or Invalid is treated as a miss. It claims the bus, invalidates every other copy and leaves the line Modified. Snoop lookups go through a second copy of the tag and state array, so they never compete with processor lookups. Both copies are written together.

Top module: `msi_snoop_cache`

## Requirements
- R1: After reset every line is Invalid: `bus_req`, `cpu_ready` and `snp_abort` are low, and the first access to any address goes to the bus.
- R2: A read that misses issues one read-miss (`bus_cmd` = 1) for the requested address. It returns `bus_rdata` on `cpu_rdata` in the cycle `bus_done` is high, with `cpu_ready` high. The line becomes Shared: a later read hits, and a later write issues a write-miss.
- R3: A write to a line that is Invalid, Shared or holds another tag issues one write-miss (`bus_cmd` = 2) for the address and leaves the line Modified with the written data.
- R4: A read of a resident line in Shared or Modified state completes in the cycle of the request (`cpu_ready` high while `cpu_req` is first presented), returns the line's latest data, and uses no bus transaction.
- R5: A write to a resident Modified line completes in the cycle of the request without any bus transaction.
- R6: A snooped read-miss (`snp_cmd` = 1) that hits a Modified line raises `snp_abort` in the same cycle, with the line's data on `snp_data`. The line becomes Shared.
- R7: A snooped write-miss (`snp_cmd` = 2) that hits a Modified line raises `snp_abort` with the line's data. The line becomes Invalid.
- R8: A snooped write-miss that hits a Shared line invalidates it without an abort. A snooped read-miss on a Shared line leaves it Shared without an abort. A snoop that does not match the line's tag, or finds it Invalid, changes nothing.
- R9: A miss whose index holds a Modified line of another tag first issues a write-back (`bus_cmd` = 3) with the victim's address and data. The fill follows on the same bus tenure, and the processor is stalled until the fill completes.
- R10: A bus command appears only after `bus_gnt`. `bus_req` stays high from the miss until the last `bus_done`, and `bus_cmd` and `bus_addr` hold steady until `bus_done`.
- R11: A processor request presented in a cycle with `snp_valid` high is not served in that cycle. It is served once the snoop has gone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 16 | Word address (upper 12 bits tag, lower 4 bits index) |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| bus_req | output | 1 | Bus arbitration request |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd | output | 2 | 0 idle, 1 read-miss, 2 write-miss, 3 write-back |
| bus_addr | output | 16 | Transaction address |
| bus_wdata | output | 32 | Write-back data |
| bus_rdata | input | 32 | Fill data, valid with `bus_done` |
| bus_done | input | 1 | Current transaction ends this cycle |
| snp_valid | input | 1 | Another agent's transaction is on the bus |
| snp_cmd | input | 2 | 1 read-miss, 2 write-miss; other codes are ignored |
| snp_addr | input | 16 | Snooped address |
| snp_abort | output | 1 | Memory must not answer; this cache supplies the data |
| snp_data | output | 32 | Flushed line data, valid with `snp_abort` |

## Verification
The hardest situation to reach is a Modified line being pulled away by a snoop while the same processor keeps using that index. This covers a flush followed by a local upgrade or refill, and a dirty victim whose tag has just changed owner. The stimulus draws addresses from only three tags per index, so conflicts are frequent. It interleaves random snoops, which carry new data from the other agent, with random loads and stores. A reference model predicts every abort, every flushed word, the exact order of bus transactions and every loaded value. Directed cases hold off the grant, and they present a snoop in the same cycle as a hit.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_MOD = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BC_NONE   = 2'd0,
    BC_RDMISS = 2'd1,
    BC_WRMISS = 2'd2,
    BC_WBACK  = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    CT_IDLE = 2'd0,
    CT_ARB  = 2'd1,
    CT_WB   = 2'd2,
    CT_FILL = 2'd3
  } ctl_st_e;
endpackage

// File: rtl/msi_tag_store.sv
module msi_tag_store
  import msi_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output line_st_e         rd_st,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  line_st_e         wr_st
);
  localparam int DEPTH = 1 << IDX_W;

  line_st_e         st_q  [DEPTH];
  logic [TAG_W-1:0] tag_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) st_q[i] <= LN_INV;
    end else if (wr_en) begin
      st_q[wr_idx] <= wr_st;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_tag = tag_q[rd_idx];
  assign rd_st  = st_q[rd_idx];
endmodule

// File: rtl/msi_data_store.sv
module msi_data_store #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  cpu_idx,
  output logic [DATA_W-1:0] cpu_data,
  input  logic [IDX_W-1:0]  snp_idx,
  output logic [DATA_W-1:0] snp_data,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[cpu_idx] <= wr_data;
  end

  assign cpu_data = mem_q[cpu_idx];
  assign snp_data = mem_q[snp_idx];
endmodule

// File: rtl/msi_miss_ctrl.sv
module msi_miss_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              snp_valid,
  output logic [IDX_W-1:0]  look_idx,
  input  logic [TAG_W-1:0]  look_tag,
  input  line_st_e          look_st,
  input  logic [DATA_W-1:0] look_data,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_done,
  output logic              fill_we,
  output logic [TAG_W-1:0]  fill_tag,
  output line_st_e          fill_st,
  output logic              data_we,
  output logic [DATA_W-1:0] data_wdata
);
  ctl_st_e           st_q, st_d;
  logic [ADDR_W-1:0] req_addr_q;
  logic              req_we_q;
  logic [DATA_W-1:0] req_wdata_q;
  bus_cmd_e          cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              req_ld, cmd_ld;
  logic [TAG_W-1:0]  cur_tag;
  logic              hit;
  bus_cmd_e          fill_cmd;

  assign look_idx = (st_q == CT_IDLE) ? cpu_addr[IDX_W-1:0] : req_addr_q[IDX_W-1:0];
  assign cur_tag  = (st_q == CT_IDLE) ? cpu_addr[ADDR_W-1:IDX_W] : req_addr_q[ADDR_W-1:IDX_W];
  assign hit      = (look_st != LN_INV) && (look_tag == cur_tag);
  assign fill_cmd = req_we_q ? BC_WRMISS : BC_RDMISS;
  assign fill_tag = req_addr_q[ADDR_W-1:IDX_W];
  assign fill_st  = req_we_q ? LN_MOD : LN_SHR;

  always_comb begin
    st_d       = st_q;
    req_ld     = 1'b0;
    cmd_ld     = 1'b0;
    cmd_d      = BC_NONE;
    addr_d     = req_addr_q;
    cpu_ready  = 1'b0;
    cpu_rdata  = look_data;
    bus_req    = 1'b0;
    bus_wdata  = '0;
    fill_we    = 1'b0;
    data_we    = 1'b0;
    data_wdata = cpu_wdata;
    case (st_q)
      CT_IDLE: begin
        if (cpu_req && !snp_valid) begin
          if (!cpu_we && hit) begin
            cpu_ready = 1'b1;
          end else if (cpu_we && hit && look_st == LN_MOD) begin
            cpu_ready = 1'b1;
            data_we   = 1'b1;
          end else begin
            req_ld = 1'b1;
            st_d   = CT_ARB;
          end
        end
      end
      CT_ARB: begin
        bus_req = 1'b1;
        if (bus_gnt) begin
          cmd_ld = 1'b1;
          if (look_st == LN_MOD && look_tag != cur_tag) begin
            cmd_d  = BC_WBACK;
            addr_d = {look_tag, req_addr_q[IDX_W-1:0]};
            st_d   = CT_WB;
          end else begin
            cmd_d = fill_cmd;
            st_d  = CT_FILL;
          end
        end
      end
      CT_WB: begin
        bus_req   = 1'b1;
        bus_wdata = look_data;
        if (bus_done) begin
          cmd_ld = 1'b1;
          cmd_d  = fill_cmd;
          st_d   = CT_FILL;
        end
      end
      default: begin
        bus_req = 1'b1;
        if (bus_done) begin
          fill_we    = 1'b1;
          data_we    = 1'b1;
          data_wdata = req_we_q ? req_wdata_q : bus_rdata;
          cpu_ready  = 1'b1;
          cpu_rdata  = bus_rdata;
          cmd_ld     = 1'b1;
          st_d       = CT_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CT_IDLE;
      cmd_q <= BC_NONE;
    end else begin
      st_q <= st_d;
      if (cmd_ld) cmd_q <= cmd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (req_ld) begin
      req_addr_q  <= cpu_addr;
      req_we_q    <= cpu_we;
      req_wdata_q <= cpu_wdata;
    end
    if (cmd_ld) addr_q <= addr_d;
  end

  assign bus_cmd  = cmd_q;
  assign bus_addr = addr_q;
endmodule

// File: rtl/msi_snoop_cache.sv
module msi_snoop_cache
  import msi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_done,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_abort,
  output logic [DATA_W-1:0] snp_data
);
  localparam int TAG_W   = ADDR_W - IDX_W;
  localparam int NCOPY   = 2;
  localparam int CPU_CPY = 0;
  localparam int SNP_CPY = 1;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [IDX_W-1:0]  rd_idx  [NCOPY];
  logic [TAG_W-1:0]  rd_tag  [NCOPY];
  line_st_e          rd_st   [NCOPY];
  logic              tag_we;
  logic [IDX_W-1:0]  tag_widx;
  logic [TAG_W-1:0]  tag_wtag;
  line_st_e          tag_wst;

  logic [IDX_W-1:0]  look_idx;
  logic [DATA_W-1:0] look_data;
  logic              fill_we, data_we;
  logic [TAG_W-1:0]  fill_tag;
  line_st_e          fill_st;
  logic [DATA_W-1:0] data_wdata;

  logic [IDX_W-1:0]  snp_idx;
  logic              snp_match, snp_upd, snp_known;
  line_st_e          snp_nst;

  assign rd_idx[CPU_CPY] = look_idx;
  assign rd_idx[SNP_CPY] = snp_idx;

  for (genvar g = 0; g < NCOPY; g++) begin : g_tag_copy
    msi_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .rd_idx (rd_idx[g]),
      .rd_tag (rd_tag[g]),
      .rd_st  (rd_st[g]),
      .wr_en  (tag_we),
      .wr_idx (tag_widx),
      .wr_tag (tag_wtag),
      .wr_st  (tag_wst)
    );
  end

  msi_data_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
    .clk      (clk),
    .cpu_idx  (look_idx),
    .cpu_data (look_data),
    .snp_idx  (snp_idx),
    .snp_data (snp_data),
    .wr_en    (data_we),
    .wr_data  (data_wdata)
  );

  msi_miss_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_ready  (cpu_ready),
    .cpu_rdata  (cpu_rdata),
    .snp_valid  (snp_valid),
    .look_idx   (look_idx),
    .look_tag   (rd_tag[CPU_CPY]),
    .look_st    (rd_st[CPU_CPY]),
    .look_data  (look_data),
    .bus_req    (bus_req),
    .bus_gnt    (bus_gnt),
    .bus_cmd    (bus_cmd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_done   (bus_done),
    .fill_we    (fill_we),
    .fill_tag   (fill_tag),
    .fill_st    (fill_st),
    .data_we    (data_we),
    .data_wdata (data_wdata)
  );

  // Snoop side: duplicate tag copy only
  assign snp_idx   = snp_addr[IDX_W-1:0];
  assign snp_known = (snp_cmd == BC_RDMISS) || (snp_cmd == BC_WRMISS);
  assign snp_match = snp_valid && snp_known && (rd_st[SNP_CPY] != LN_INV) &&
                     (rd_tag[SNP_CPY] == snp_addr[ADDR_W-1:IDX_W]);
  assign snp_abort = snp_match && (rd_st[SNP_CPY] == LN_MOD);
  assign snp_upd   = snp_match && ((snp_cmd == BC_WRMISS) || (rd_st[SNP_CPY] == LN_MOD));
  assign snp_nst   = (snp_cmd == BC_WRMISS) ? LN_INV : LN_SHR;

  // Shared write port: own fill takes precedence over a snoop update
  assign tag_we   = fill_we || snp_upd;
  assign tag_widx = fill_we ? look_idx : snp_idx;
  assign tag_wtag = fill_we ? fill_tag : rd_tag[SNP_CPY];
  assign tag_wst  = fill_we ? fill_st  : snp_nst;
endmodule

// File: rtl/msi_snoop_cache_chk.sv
module msi_snoop_cache_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic        bus_gnt,
  input logic [1:0]  bus_cmd,
  input logic [15:0] bus_addr,
  input logic        bus_done,
  input logic        snp_valid,
  input logic        snp_abort
);
  // R10
  cmd_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd != 2'd0 && $past(bus_cmd) == 2'd0) |-> $past(bus_gnt));

  // R10
  cmd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd != 2'd0 && !bus_done) |=> ($stable(bus_cmd) && $stable(bus_addr)));

  // R10
  req_covers_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd != 2'd0) |-> bus_req);

  // R9
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == 2'd3 && bus_done) |=> (bus_cmd == 2'd1 || bus_cmd == 2'd2));

  // R6
  abort_needs_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_abort |-> snp_valid);
endmodule

bind msi_snoop_cache msi_snoop_cache_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req   (bus_req),
  .bus_gnt   (bus_gnt),
  .bus_cmd   (bus_cmd),
  .bus_addr  (bus_addr),
  .bus_done  (bus_done),
  .snp_valid (snp_valid),
  .snp_abort (snp_abort)
);

// File: tb/msi_snoop_cache_tb.sv
module msi_snoop_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        bus_req, bus_gnt = 1'b0;
  logic [1:0]  bus_cmd;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata = '0;
  logic        bus_done = 1'b0;
  logic        snp_valid = 1'b0;
  logic [1:0]  snp_cmd = '0;
  logic [15:0] snp_addr = '0;
  logic        snp_abort;
  logic [31:0] snp_data;

  always #2.5 clk = ~clk;

  msi_snoop_cache dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit hold_gnt = 1'b0;
  int bcnt = 0;
  logic [1:0]  log_cmd [8];
  logic [15:0] log_addr [8];
  logic [31:0] log_wd [8];
  int log_n = 0;
  logic [31:0] mem  [int];
  logic [31:0] gold [int];
  int          m_st  [16];
  logic [11:0] m_tag [16];

  function automatic logic [31:0] base_val(input logic [15:0] a);
    return {a ^ 16'hA5C3, a};
  endfunction
  function automatic logic [31:0] mem_rd(input logic [15:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : base_val(a);
  endfunction
  function automatic logic [31:0] gold_rd(input logic [15:0] a);
    return gold.exists(int'(a)) ? gold[int'(a)] : base_val(a);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Bus arbiter and memory, latency 2 cycles
  always @(negedge clk) begin
    if (rst_n) begin
      bus_gnt = bus_req && !hold_gnt;
      if (bus_done) begin
        bus_done = 1'b0;
        bcnt = 0;
      end else if (bus_cmd != 2'd0) begin
        bcnt++;
        if (bcnt == 2) begin
          if (log_n < 8) begin
            log_cmd[log_n] = bus_cmd; log_addr[log_n] = bus_addr; log_wd[log_n] = bus_wdata;
          end
          log_n++;
          if (bus_cmd == 2'd3) mem[int'(bus_addr)] = bus_wdata;
          else bus_rdata = mem_rd(bus_addr);
          bus_done = 1'b1;
        end
      end
    end
  end

  task automatic cpu_op(input bit we, input logic [15:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int ncyc);
    log_n = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; ncyc = 0;
    #1;
    while (!cpu_ready && ncyc < 200) begin
      @(negedge clk); #1; ncyc++;
    end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  // Model-checked processor access
  task automatic do_cpu(input bit we, input logic [15:0] a, input logic [31:0] wd);
    int i = int'(a[3:0]);
    logic [11:0] t = a[15:4];
    bit hit = (m_st[i] != 0) && (m_tag[i] == t);
    bit victim = (m_st[i] == 2) && (m_tag[i] != t);
    logic [15:0] vaddr = {m_tag[i], a[3:0]};
    logic [31:0] vdata = gold_rd(vaddr);
    logic [31:0] rd;
    int nc, k;
    bit quick = we ? (hit && m_st[i] == 2) : hit;
    cpu_op(we, a, wd, rd, nc);
    if (quick) begin
      check(nc == 0 && log_n == 0, we ? "R5 write hit local" : "R4 read hit local", nc, 0);
    end else begin
      check(log_n == (victim ? 2 : 1), "R9 transaction count", log_n, victim ? 2 : 1);
      k = 0;
      if (victim && log_n == 2) begin
        check(log_cmd[0] == 2'd3 && log_addr[0] == vaddr, "R9 victim writeback addr", log_addr[0], vaddr);
        check(log_wd[0] == vdata, "R9 victim writeback data", log_wd[0], vdata);
        k = 1;
      end
      if (log_n > k)
        check(log_cmd[k] == (we ? 2'd2 : 2'd1) && log_addr[k] == a,
              we ? "R3 write-miss issued" : "R2 read-miss issued", log_addr[k], a);
    end
    if (!we) check(rd == gold_rd(a), hit ? "R4 read data" : "R2 fill data", rd, gold_rd(a));
    if (we) gold[int'(a)] = wd;
    m_tag[i] = t;
    m_st[i]  = we ? 2 : (hit ? m_st[i] : 1);
  endtask

  // Model-checked snoop from the other agent
  task automatic do_snoop(input bit wr, input logic [15:0] a, input logic [31:0] nv);
    int i = int'(a[3:0]);
    bit hit = (m_st[i] != 0) && (m_tag[i] == a[15:4]);
    bit exp_ab = hit && m_st[i] == 2;
    bit ab;
    logic [31:0] d;
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = wr ? 2'd2 : 2'd1; snp_addr = a;
    #1; ab = snp_abort; d = snp_data;
    @(negedge clk);
    snp_valid = 1'b0; snp_cmd = 2'd0;
    check(ab == exp_ab, wr ? (exp_ab ? "R7 abort" : "R8 no abort") : (exp_ab ? "R6 abort" : "R8 no abort"),
          {31'd0, ab}, {31'd0, exp_ab});
    if (exp_ab) begin
      check(d == gold_rd(a), wr ? "R7 flush data" : "R6 flush data", d, gold_rd(a));
      mem[int'(a)] = d;
    end
    if (wr) begin
      gold[int'(a)] = nv; mem[int'(a)] = nv;
      if (hit) m_st[i] = 0;
    end else if (exp_ab) begin
      m_st[i] = 1;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    int nc;
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 16; i++) begin m_st[i] = 0; m_tag[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1 reset state
    check(!bus_req && !cpu_ready && !snp_abort, "R1 outputs idle after reset",
          {29'd0, bus_req, cpu_ready, snp_abort}, 0);
    do_cpu(1'b0, 16'h0010, '0);       // R1 first read goes to the bus, R2 fill as Shared
    do_cpu(1'b0, 16'h0010, '0);       // R4 hit
    do_cpu(1'b1, 16'h0010, 32'h1111); // R3 write to Shared upgrades
    do_cpu(1'b1, 16'h0010, 32'h2222); // R5 write hit on Modified
    do_snoop(1'b0, 16'h0010, '0);     // R6 read snoop flushes, line Shared
    do_snoop(1'b0, 16'h0010, '0);     // R8 second read snoop: no abort
    do_cpu(1'b1, 16'h0010, 32'h3333); // R3 upgrade again
    do_snoop(1'b1, 16'h0010, 32'h4444); // R7 write snoop flushes, line Invalid
    do_cpu(1'b0, 16'h0010, '0);       // R2 refill sees other agent's value
    do_snoop(1'b1, 16'h0010, 32'h5555); // R8 write snoop on Shared invalidates
    do_cpu(1'b1, 16'h0023, 32'h6666);
    do_cpu(1'b0, 16'h0053, '0);       // R9 dirty victim first
    do_snoop(1'b1, 16'h0073, 32'h7777); // R8 tag mismatch: nothing

    // R10 grant held off: no command until granted
    hold_gnt = 1'b1;
    fork
      do_cpu(1'b0, 16'h0044, '0);
      begin
        repeat (4) @(negedge clk);
        #2;
        check(bus_req && bus_cmd == 2'd0 && !cpu_ready, "R10 wait for grant", {30'd0, bus_cmd}, 0);
        hold_gnt = 1'b0;
      end
    join

    // R11 snoop in the same cycle as a read hit
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = 16'h0FF9;
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'h0044;
    #1;
    check(!cpu_ready, "R11 held off during snoop", {31'd0, cpu_ready}, 0);
    @(negedge clk);
    snp_valid = 1'b0; snp_cmd = 2'd0;
    #1;
    check(cpu_ready && cpu_rdata == gold_rd(16'h0044), "R11 served after snoop", cpu_rdata, gold_rd(16'h0044));
    @(negedge clk);
    cpu_req = 1'b0;

    for (int n = 0; n < 600; n++) begin
      logic [15:0] a;
      int r = int'($urandom_range(0, 9));
      a = {12'(32'($urandom_range(0, 2)) * 12'd3 + 12'd1), 4'($urandom_range(0, 15))};
      if (r < 3) do_snoop(r == 0, a, $urandom);
      else if (r < 6) do_cpu(1'b1, a, $urandom);
      else do_cpu(1'b0, a, '0);
    end
    // R1 again: idle outputs after traffic
    @(negedge clk); #1;
    check(!bus_req && !cpu_ready, "R1 idle at end", {30'd0, bus_req, cpu_ready}, 0);
    finish_run();
  end
endmodule